// File: doc/BRIEF.md
# Disk DMA Transfer Sequencer

The sequencer runs one storage command that is moved in several chunks by a DMA channel. A command start loads the byte budget of the transfer, either a sector count for a disk or a byte count for a packet (optical) device. The sequencer then pulses a kick to the channel. Each chunk the channel offers is answered with one response code. A chunk that moves data is passed as a single request to a downstream aligner, with the operation, the device byte offset and the length. The sequencer waits for the aligner to finish before it updates its counters and accepts the next chunk.

A chunk that arrives while no command is active is parked and not served. A zero-length chunk closes the current descriptor only. A chunk that arrives after the budget is used up ends the command: a disk raises ready and seek-complete status and the interrupt, a packet device pulses command-OK. A chunk that reports an error stops the command and raises the error flag. A packet command whose LBA is all ones reads no blocks. It copies straight from the device buffer and completes in one step.

Top module: `dma_xfer_seq`

## Requirements
- R1: When `start_i` is seen at a clock edge, the next cycle shows `kick_o`=1 for one cycle and `active_o`=1. The remaining budget becomes `nsec_i`*512 for a disk (`pkt_i`=0) or `pkt_size_i` for a packet device (`pkt_i`=1). The index becomes 0, and `err_o`, `stat_rdy_o` and `stat_seek_o` are cleared.
- R2: A chunk accepted while `active_o`=0 gets response code 1 (park). Nothing is issued to the aligner.
- R3: For a disk, a chunk accepted while the remaining budget is zero or negative gets response code 3 (end of command). In the same cycle `irq_o` pulses, `stat_rdy_o` and `stat_seek_o` go to 1, and `active_o` clears.
- R4: For a packet device, the same end-of-command case pulses `cmd_ok_o` together with response code 3 and clears `active_o`. `irq_o` stays 0.
- R5: A zero-length chunk with budget left gets response code 2 (end of descriptor). `active_o` stays 1 and the next chunk is served normally.
- R6: The aligner offset is `lba_i`*512 plus the index for a disk, and `lba_i`*2048 plus the index for a packet device.
- R7: The aligner request, once made, holds until `al_done_i`. The cycle after `al_done_i` shows response code 0 (served). The index then grows by the chunk length and the remaining budget drops by it, and may go negative.
- R8: For a packet command with `lba_i` all ones, a data chunk issues op 3 (copy) with length min(remaining, chunk length) and offset equal to the index. On `al_done_i` it ends the command with code 3 and a `cmd_ok_o` pulse.
- R9: Disk ops are encoded 0 read, 1 write, 2 trim and are passed to `al_op_o` unchanged. Packet devices always use 0. A disk command with op 3 answers its first data chunk with code 4 (error), sets `err_o` and clears `active_o`.
- R10: A chunk offered with `chunk_err_i`=1 gets code 4 whatever the state. It sets `err_o`, clears `active_o` and issues nothing.
- R11: Only one aligner request is outstanding. `chunk_rdy_o` is 0 from issue until the cycle after `al_done_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| start_i | input | 1 | command start pulse |
| pkt_i | input | 1 | 1 = packet device, 0 = disk |
| op_i | input | 2 | disk op: 0 read, 1 write, 2 trim, 3 illegal |
| lba_i | input | LBA_W | start sector or packet LBA |
| nsec_i | input | CNT_W | disk sector count |
| pkt_size_i | input | SZ_W | packet transfer size in bytes |
| kick_o | output | 1 | channel start pulse |
| chunk_req_i | input | 1 | channel offers a chunk |
| chunk_len_i | input | LEN_W | chunk length in bytes |
| chunk_err_i | input | 1 | chunk carries an error |
| chunk_rdy_o | output | 1 | sequencer can take a chunk |
| resp_valid_o | output | 1 | chunk response valid |
| resp_code_o | output | 3 | 0 served, 1 park, 2 end descriptor, 3 end command, 4 error |
| al_req_o | output | 1 | aligner request |
| al_op_o | output | 2 | 0 read, 1 write, 2 trim, 3 copy |
| al_off_o | output | LBA_W+12 | device byte offset |
| al_len_o | output | LEN_W | byte length |
| al_done_i | input | 1 | aligner finished |
| active_o | output | 1 | command active |
| stat_rdy_o | output | 1 | ready status |
| stat_seek_o | output | 1 | seek-complete status |
| err_o | output | 1 | error status |
| irq_o | output | 1 | disk completion interrupt pulse |
| cmd_ok_o | output | 1 | packet completion pulse |

## Verification
The hardest state to reach is a budget driven below zero. A chunk longer than the remaining bytes is served in full, and only the chunk after it may end the command. The sweep pairs sector counts with chunk lengths that do not divide them, such as 700 bytes against 512-byte sectors, so the overshoot and the late end are reached. The park path needs a chunk offered after the command has already ended, so every sweep run offers one more chunk after the end.

// File: rtl/dxs_pkg.sv
package dxs_pkg;
  typedef enum logic {S_IDLE, S_BUSY} dxs_state_e;
  typedef enum logic [2:0] {
    RSP_DONE = 3'd0, RSP_PARK = 3'd1, RSP_EOD = 3'd2, RSP_EOC = 3'd3, RSP_ERR = 3'd4
  } dxs_resp_e;
  localparam logic [1:0] OP_READ = 2'd0;
  localparam logic [1:0] OP_COPY = 2'd3;
endpackage

// File: rtl/dxs_offset.sv
module dxs_offset #(
  parameter int LBA_W = 24,
  parameter int IDX_W = 21,
  localparam int OFF_W = LBA_W + 12
) (
  input  logic             pkt_i,
  input  logic [LBA_W-1:0] lba_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [OFF_W-1:0] off_o
);
  logic [OFF_W-1:0] base;
  always_comb begin
    if (pkt_i) base = {1'b0, lba_i, 11'b0};
    else       base = {3'b0, lba_i, 9'b0};
    off_o = base + {{(OFF_W-IDX_W){1'b0}}, idx_i};
  end
endmodule

// File: rtl/dxs_counters.sv
module dxs_counters #(
  parameter int REM_W = 21,
  parameter int LEN_W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_i,
  input  logic signed [REM_W-1:0] load_val_i,
  input  logic                    step_i,
  input  logic [LEN_W-1:0]        step_len_i,
  input  logic                    clr_i,
  output logic signed [REM_W-1:0] rem_o,
  output logic [REM_W-1:0]        idx_o
);
  logic [REM_W-1:0] len_ext;
  assign len_ext = {{(REM_W-LEN_W){1'b0}}, step_len_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_o <= '0;
      idx_o <= '0;
    end else if (load_i) begin
      rem_o <= load_val_i;
      idx_o <= '0;
    end else if (clr_i) begin
      rem_o <= '0;
    end else if (step_i) begin
      rem_o <= rem_o - $signed(len_ext);
      idx_o <= idx_o + len_ext;
    end
  end

  assert_index_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && !clr_i) |=> idx_o == $past(idx_o) + $past(len_ext));
endmodule

// File: rtl/dma_xfer_seq.sv
module dma_xfer_seq
  import dxs_pkg::*;
#(
  parameter int LBA_W = 24,
  parameter int CNT_W = 8,
  parameter int SZ_W  = 20,
  parameter int LEN_W = 16,
  localparam int OFF_W = LBA_W + 12,
  localparam int REM_W = ((SZ_W > CNT_W + 9) ? SZ_W : CNT_W + 9) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             pkt_i,
  input  logic [1:0]       op_i,
  input  logic [LBA_W-1:0] lba_i,
  input  logic [CNT_W-1:0] nsec_i,
  input  logic [SZ_W-1:0]  pkt_size_i,
  output logic             kick_o,
  input  logic             chunk_req_i,
  input  logic [LEN_W-1:0] chunk_len_i,
  input  logic             chunk_err_i,
  output logic             chunk_rdy_o,
  output logic             resp_valid_o,
  output logic [2:0]       resp_code_o,
  output logic             al_req_o,
  output logic [1:0]       al_op_o,
  output logic [OFF_W-1:0] al_off_o,
  output logic [LEN_W-1:0] al_len_o,
  input  logic             al_done_i,
  output logic             active_o,
  output logic             stat_rdy_o,
  output logic             stat_seek_o,
  output logic             err_o,
  output logic             irq_o,
  output logic             cmd_ok_o
);
  dxs_state_e       state_q;
  logic             pkt_q, copy_q;
  logic [1:0]       op_q;
  logic [LBA_W-1:0] lba_q;
  logic [LEN_W-1:0] len_q;
  logic signed [REM_W-1:0] rem, load_val;
  logic [REM_W-1:0] idx, len_ext;
  logic [OFF_W-1:0] off;
  logic             take, step, clr, rem_done, nonblock;
  logic [LEN_W-1:0] copy_len;

  assign take     = chunk_req_i && state_q == S_IDLE && !start_i;
  assign step     = state_q == S_BUSY && al_done_i && !copy_q && !start_i;
  assign clr      = state_q == S_BUSY && al_done_i && copy_q && !start_i;
  assign rem_done = rem <= 0;
  assign nonblock = pkt_q && (&lba_q);
  assign len_ext  = {{(REM_W-LEN_W){1'b0}}, chunk_len_i};
  assign copy_len = ($unsigned(rem) < len_ext) ? rem[LEN_W-1:0] : chunk_len_i;
  assign chunk_rdy_o = state_q == S_IDLE;

  always_comb begin
    if (pkt_i) load_val = $signed({{(REM_W-SZ_W){1'b0}}, pkt_size_i});
    else       load_val = $signed({{(REM_W-CNT_W-9){1'b0}}, nsec_i, 9'b0});
  end

  dxs_counters #(.REM_W(REM_W), .LEN_W(LEN_W)) u_cnt (
    .clk_i, .rst_ni,
    .load_i(start_i), .load_val_i(load_val),
    .step_i(step), .step_len_i(len_q), .clr_i(clr),
    .rem_o(rem), .idx_o(idx)
  );

  dxs_offset #(.LBA_W(LBA_W), .IDX_W(REM_W)) u_off (
    .pkt_i(pkt_q), .lba_i(lba_q), .idx_i(idx), .off_o(off)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      pkt_q <= 1'b0; copy_q <= 1'b0; op_q <= '0; lba_q <= '0; len_q <= '0;
      kick_o <= 1'b0; resp_valid_o <= 1'b0; resp_code_o <= RSP_DONE;
      al_req_o <= 1'b0; al_op_o <= '0; al_off_o <= '0; al_len_o <= '0;
      active_o <= 1'b0; stat_rdy_o <= 1'b0; stat_seek_o <= 1'b0;
      err_o <= 1'b0; irq_o <= 1'b0; cmd_ok_o <= 1'b0;
    end else begin
      kick_o <= 1'b0; resp_valid_o <= 1'b0; irq_o <= 1'b0; cmd_ok_o <= 1'b0;
      if (start_i) begin
        pkt_q <= pkt_i; op_q <= op_i; lba_q <= lba_i;
        active_o <= 1'b1; kick_o <= 1'b1;
        stat_rdy_o <= 1'b0; stat_seek_o <= 1'b0; err_o <= 1'b0;
        al_req_o <= 1'b0; state_q <= S_IDLE;
      end else if (take) begin
        resp_valid_o <= 1'b1;
        if (chunk_err_i) begin
          resp_code_o <= RSP_ERR; err_o <= 1'b1; active_o <= 1'b0;
        end else if (!active_o) begin
          resp_code_o <= RSP_PARK;
        end else if (rem_done) begin
          resp_code_o <= RSP_EOC; active_o <= 1'b0;
          if (pkt_q) cmd_ok_o <= 1'b1;
          else begin
            irq_o <= 1'b1; stat_rdy_o <= 1'b1; stat_seek_o <= 1'b1;
          end
        end else if (chunk_len_i == '0) begin
          resp_code_o <= RSP_EOD;
        end else if (nonblock) begin
          resp_valid_o <= 1'b0;
          al_req_o <= 1'b1; al_op_o <= OP_COPY; al_len_o <= copy_len;
          al_off_o <= {{(OFF_W-REM_W){1'b0}}, idx};
          copy_q <= 1'b1; state_q <= S_BUSY;
        end else if (!pkt_q && op_q == OP_COPY) begin
          resp_code_o <= RSP_ERR; err_o <= 1'b1; active_o <= 1'b0;
        end else begin
          resp_valid_o <= 1'b0;
          al_req_o <= 1'b1; al_op_o <= pkt_q ? OP_READ : op_q;
          al_off_o <= off; al_len_o <= chunk_len_i; len_q <= chunk_len_i;
          copy_q <= 1'b0; state_q <= S_BUSY;
        end
      end else if (state_q == S_BUSY && al_done_i) begin
        al_req_o <= 1'b0; state_q <= S_IDLE; resp_valid_o <= 1'b1;
        if (copy_q) begin
          resp_code_o <= RSP_EOC; cmd_ok_o <= 1'b1; active_o <= 1'b0;
        end else begin
          resp_code_o <= RSP_DONE;
        end
      end
    end
  end

  assert_kick_on_start_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> kick_o && active_o);
  assert_park_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && !active_o && !chunk_err_i) |=> resp_valid_o && resp_code_o == RSP_PARK && !al_req_o);
  assert_irq_status_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> stat_rdy_o && stat_seek_o && !active_o && !cmd_ok_o);
  assert_err_stops_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && chunk_err_i) |=> err_o && !active_o && !al_req_o);
  assert_req_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (al_req_o && !al_done_i && !start_i) |=> al_req_o && !chunk_rdy_o);
endmodule

// File: tb/tb_dma_xfer_seq.sv
module tb_dma_xfer_seq;
  localparam int LBA_W = 24, CNT_W = 8, SZ_W = 20, LEN_W = 16, OFF_W = LBA_W + 12;

  logic clk_i = 0, rst_ni = 0;
  logic start_i = 0, pkt_i = 0, chunk_req_i = 0, chunk_err_i = 0, al_done_i = 0;
  logic [1:0] op_i = 0;
  logic [LBA_W-1:0] lba_i = 0;
  logic [CNT_W-1:0] nsec_i = 0;
  logic [SZ_W-1:0] pkt_size_i = 0;
  logic [LEN_W-1:0] chunk_len_i = 0;
  logic kick_o, chunk_rdy_o, resp_valid_o, al_req_o, active_o;
  logic stat_rdy_o, stat_seek_o, err_o, irq_o, cmd_ok_o;
  logic [2:0] resp_code_o;
  logic [1:0] al_op_o;
  logic [OFF_W-1:0] al_off_o;
  logic [LEN_W-1:0] al_len_o;

  dma_xfer_seq dut (.*);

  always #4 clk_i = ~clk_i;

  int total = 0, bad = 0;
  longint m_rem, m_idx, m_lba;
  bit m_act, m_pkt;
  int m_op;

  task automatic check(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_start(bit pkt, int op, longint lba, int nsec, int psize);
    @(negedge clk_i);
    start_i = 1; pkt_i = pkt; op_i = op[1:0]; lba_i = lba[LBA_W-1:0];
    nsec_i = nsec[CNT_W-1:0]; pkt_size_i = psize[SZ_W-1:0];
    @(negedge clk_i);
    start_i = 0;
    check("R1 kick", kick_o, 1);
    check("R1 active", active_o, 1);
    check("R1 err clear", err_o, 0);
    m_pkt = pkt; m_op = op; m_lba = lba; m_act = 1; m_idx = 0;
    m_rem = pkt ? psize : nsec * 512;
  endtask

  // returns response code seen
  task automatic do_chunk(int len, bit err, output int code);
    int exp_code; bit issue, copy;
    longint exp_off, exp_len; int exp_op;
    issue = 0; copy = 0; exp_off = 0; exp_len = 0; exp_op = 0; exp_code = 0;
    if (err) exp_code = 4;
    else if (!m_act) exp_code = 1;
    else if (m_rem <= 0) exp_code = 3;
    else if (len == 0) exp_code = 2;
    else if (m_pkt && m_lba == (1 << LBA_W) - 1) begin
      copy = 1; issue = 1; exp_op = 3; exp_off = m_idx;
      exp_len = (m_rem < len) ? m_rem : len; exp_code = 3;
    end else if (!m_pkt && m_op == 3) exp_code = 4;
    else begin
      issue = 1; exp_op = m_pkt ? 0 : m_op; exp_len = len; exp_code = 0;
      exp_off = (m_pkt ? m_lba * 2048 : m_lba * 512) + m_idx;
    end
    @(negedge clk_i);
    chunk_req_i = 1; chunk_len_i = len[LEN_W-1:0]; chunk_err_i = err;
    @(negedge clk_i);
    chunk_req_i = 0; chunk_err_i = 0;
    if (issue) begin
      check("R11 req", al_req_o, 1);
      check("R11 not ready", chunk_rdy_o, 0);
      check("R9 op", al_op_o, exp_op);
      check(copy ? "R8 off" : "R6 off", al_off_o, exp_off);
      check(copy ? "R8 len" : "R7 len", al_len_o, exp_len);
      @(negedge clk_i);
      check("R11 held", al_req_o, 1);
      al_done_i = 1;
      @(negedge clk_i);
      al_done_i = 0;
    end
    check("R7 resp valid", resp_valid_o, 1);
    check("resp code R2 R5 R7", resp_code_o, exp_code);
    code = resp_code_o;
    if (exp_code == 4) begin
      check("R10 err", err_o, 1);
      check("R10 inactive", active_o, 0);
      m_act = 0;
    end else if (exp_code == 3) begin
      check("R3 R4 inactive", active_o, 0);
      check("R4 cmd_ok", cmd_ok_o, m_pkt);
      check("R3 irq", irq_o, !m_pkt);
      if (!m_pkt) begin
        check("R3 rdy", stat_rdy_o, 1);
        check("R3 seek", stat_seek_o, 1);
      end
      m_act = 0;
    end else if (exp_code == 2) begin
      check("R5 still active", active_o, 1);
    end else if (exp_code == 1) begin
      check("R2 no req", al_req_o, 0);
    end
    if (exp_code == 0) begin
      m_rem -= len; m_idx += len;
    end
    if (copy) m_rem = 0;
  endtask

  initial begin : wd
    repeat (150000) @(posedge clk_i);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int code;
    int lens[3] = '{256, 512, 700};
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    check("R1 reset active", active_o, 0);
    check("R11 reset rdy", chunk_rdy_o, 1);
    check("R3 reset irq", irq_o, 0);
    m_act = 0; m_pkt = 0; m_op = 0; m_lba = 0; m_rem = 0; m_idx = 0;
    do_chunk(512, 0, code); // R2 park before any start

    for (int k = 0; k < 2; k++)
      for (int op = 0; op < (k ? 1 : 3); op++)
        for (int ns = 1; ns <= 3; ns++)
          for (int li = 0; li < 3; li++) begin
            do_start(k[0], op, 100 + ns * 7 + li, ns, ns * 600);
            for (int n = 0; n < 20; n++) begin
              do_chunk(lens[li], 0, code);
              if (code != 0) break;
            end
            do_chunk(lens[li], 0, code); // R2 park after end
          end

    // R5 zero-length descriptor end, then continue
    do_start(0, 1, 40, 2, 0);
    do_chunk(512, 0, code);
    do_chunk(0, 0, code);
    do_chunk(512, 0, code);
    do_chunk(512, 0, code);
    // R10 error mid-command, then park
    do_start(1, 0, 9, 0, 4096);
    do_chunk(1024, 0, code);
    do_chunk(1024, 1, code);
    do_chunk(1024, 0, code);
    // R9 illegal disk op
    do_start(0, 3, 3, 4, 0);
    do_chunk(512, 0, code);
    // R8 non-block copy, short and long budget
    do_start(1, 0, (1 << LBA_W) - 1, 0, 300);
    do_chunk(512, 0, code);
    do_start(1, 0, (1 << LBA_W) - 1, 0, 900);
    do_chunk(512, 0, code);
    // R3 zero-sector disk command ends on first chunk
    do_start(0, 0, 1, 0, 0);
    do_chunk(512, 0, code);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule